// File: doc/BRIEF.md
# Event Buffer Manager with Fast Clear

This block keeps track of a circular buffer of event slots in the data memory of a multichannel digitizer. Each accepted gate opens a slot at the current write pointer. Converted channel words are stamped with a parity bit, the channel number and the module's geographic address, and then written into that slot. When the gate falls, a fast-clear window of a fixed number of clock cycles begins. If the window runs out with no clear, the event is committed and the write pointer advances. If a clear arrives inside the window, the event is dropped: the pointer stays where it was, and the next event overwrites the slot.

Four clear sources are merged into one clear:
- a front-panel line;
- a trigger line from an external controller;
- a broadcast bus strobe;
- a high bit in a control-register write.

The two external lines can pass through a configurable synchronizer. After any clear, `ready` stays low for a recovery time given in nanoseconds. No gate is accepted during that time, and none is accepted while the buffer is full.

The host reads events out by pulsing an acknowledge, which advances the read pointer. For test purposes it can also write raw words to any memory address. Such words are stored exactly as given, with no fields added.

Top module: `evbuf_mgr`

## Requirements
- R1: A gate accepted while `ready_o` is high is followed, once it falls, by a window of FCW_CYC cycles. If no clear is taken, `wr_ptr_o` advances by one on the FCW_CYC-th rising edge after the edge that sees the gate low. `ready_o` stays low from gate acceptance until that commit.
- R2: A clear taken inside the window leaves `wr_ptr_o` unchanged. The next event reuses the same slot addresses.
- R3: A clear is produced by any one of these: `fc_panel_i`, `fc_trig_i` (each delayed by SYNC_STAGES flops), `fc_bcast_i`, or `csr0_we_i` with bit 31 of `csr0_wdata_i` set.
- R4: Clear requests that arrive while no window is open have no effect. This covers the idle state, a high gate, and the time after the window has expired. A control write with bit 31 low never clears.
- R5: When a clear reaches the sequencer in the last cycle of the window, the clear wins and no commit happens.
- R6: After a clear, `ready_o` is low for exactly CLK_MHZ*RECOVER_NS/1000 cycles. A gate that rises during that time is ignored, even if it is still high when recovery ends.
- R7: `full_o` is high when EVENTS events are committed and unread. While it is high, `ready_o` is low and gates are ignored. `empty_o` is high when no event is unread.
- R8: `rd_ack_i` advances `rd_ptr_o` by one when the buffer is not empty, and is ignored when it is empty.
- R9: An accepted acquisition word is written one cycle later. Its address is `{wr_ptr, index}`, where the index starts at 0 for each gate. Its data is the value in bits 15:0, the channel in bits 21:16, the geographic address in bits 26:22, zeros in bits 30:27, and in bit 31 the XOR of bits 30:0.
- R10: A single host write (`host_burst_i` low) stores `host_wdata_i` unchanged at `host_addr_i` one cycle later.
- R11: A host write with `host_burst_i` high produces no memory write and raises `host_nak_o` one cycle later.
- R12: When an acquisition word and a host write arrive in the same cycle, the acquisition word is written and the host write is refused with `host_nak_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gate_i | input | 1 | Gate level; its rising edge starts an event |
| ready_o | output | 1 | High when a new gate will be accepted |
| fc_panel_i | input | 1 | Front-panel fast clear |
| fc_trig_i | input | 1 | External trigger-line fast clear |
| fc_bcast_i | input | 1 | Broadcast-write fast clear strobe |
| csr0_we_i | input | 1 | Control register 0 write strobe |
| csr0_wdata_i | input | DATA_W | Control register 0 write data; bit 31 requests a clear |
| geo_i | input | GEO_W | Geographic address of the module |
| acq_we_i | input | 1 | Converted word valid |
| acq_chan_i | input | CH_W | Channel number of the converted word |
| acq_val_i | input | VAL_W | Converted value |
| host_we_i | input | 1 | Host test write strobe |
| host_burst_i | input | 1 | Marks the host write as part of a block transfer |
| host_addr_i | input | MEM_AW | Host write address |
| host_wdata_i | input | DATA_W | Host write data |
| rd_ack_i | input | 1 | Host has read out the oldest event |
| wr_ptr_o | output | EV_AW | Slot index of the next event to be written |
| rd_ptr_o | output | EV_AW | Slot index of the oldest unread event |
| empty_o | output | 1 | No unread event |
| full_o | output | 1 | All slots hold unread events |
| mem_we_o | output | 1 | Data memory write enable |
| mem_addr_o | output | MEM_AW | Data memory write address |
| mem_wdata_o | output | DATA_W | Data memory write data |
| host_nak_o | output | 1 | Host write refused |

## Verification
The bench builds the block with four event slots, a six-cycle window, a 64 ns recovery time at 125 MHz (eight cycles) and a two-stage synchronizer on the external clear lines. With four slots, the full and wrap-around conditions are reached after a handful of commits. The short recovery time makes it practical to check exactly when `ready_o` rises again. Together with the short window, the synchronizer delay lets a front-panel pulse that is sent inside the window land after the window has closed. This exercises both the late-ignore case and the case where a clear meets the expiry in the same cycle.

// File: rtl/evb_pkg.sv
package evb_pkg;
   typedef enum logic [1:0] {
      EVB_IDLE  = 2'd0,
      EVB_GATE  = 2'd1,
      EVB_WIN   = 2'd2,
      EVB_RECOV = 2'd3
   } evb_state_e;
endpackage

// File: rtl/evb_clrmerge.sv
module evb_clrmerge #(
   parameter int DATA_W      = 32,
   parameter int CLR_BIT     = 31,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              panel_i,
   input  logic              trig_i,
   input  logic              bcast_i,
   input  logic              csr_we_i,
   input  logic [DATA_W-1:0] csr_wdata_i,
   output logic              clr_req_o
);
   logic panel_s, trig_s;

   if (SYNC_STAGES == 0) begin : g_direct
      assign panel_s = panel_i;
      assign trig_s  = trig_i;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] pan_sh, trg_sh;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pan_sh <= '0;
            trg_sh <= '0;
         end else begin
            for (int k = SYNC_STAGES-1; k > 0; k--) begin
               pan_sh[k] <= pan_sh[k-1];
               trg_sh[k] <= trg_sh[k-1];
            end
            pan_sh[0] <= panel_i;
            trg_sh[0] <= trig_i;
         end
      end
      assign panel_s = pan_sh[SYNC_STAGES-1];
      assign trig_s  = trg_sh[SYNC_STAGES-1];
   end

   assign clr_req_o = panel_s | trig_s | bcast_i | (csr_we_i & csr_wdata_i[CLR_BIT]);
endmodule

// File: rtl/evb_seq.sv
module evb_seq
   import evb_pkg::*;
#(
   parameter int FCW_CYC = 16,
   parameter int REC_CYC = 125,
   parameter int CNT_W   = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic gate_i,
   input  logic full_i,
   input  logic clr_req_i,
   output logic ready_o,
   output logic open_o,
   output logic start_o,
   output logic commit_o,
   output logic clr_take_o
);
   evb_state_e state_q, state_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic gate_q;

   always_comb begin
      state_d    = state_q;
      cnt_d      = cnt_q;
      start_o    = 1'b0;
      commit_o   = 1'b0;
      clr_take_o = 1'b0;
      case (state_q)
         EVB_IDLE: begin
            if (gate_i && !gate_q && !full_i) begin
               state_d = EVB_GATE;
               start_o = 1'b1;
            end
         end
         EVB_GATE: begin
            if (!gate_i) begin
               state_d = EVB_WIN;
               cnt_d   = CNT_W'(FCW_CYC - 1);
            end
         end
         EVB_WIN: begin
            if (clr_req_i) begin
               clr_take_o = 1'b1;
               state_d    = EVB_RECOV;
               cnt_d      = CNT_W'(REC_CYC - 1);
            end else if (cnt_q == '0) begin
               commit_o = 1'b1;
               state_d  = EVB_IDLE;
            end else begin
               cnt_d = cnt_q - 1'b1;
            end
         end
         default: begin
            if (cnt_q == '0) state_d = EVB_IDLE;
            else             cnt_d   = cnt_q - 1'b1;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= EVB_IDLE;
         cnt_q   <= '0;
         gate_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
         gate_q  <= gate_i;
      end
   end

   assign ready_o = (state_q == EVB_IDLE) && !full_i;
   assign open_o  = (state_q == EVB_GATE) || (state_q == EVB_WIN);
endmodule

// File: rtl/evb_ptrs.sv
module evb_ptrs #(
   parameter int EV_AW = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             commit_i,
   input  logic             rd_ack_i,
   output logic [EV_AW-1:0] wr_ptr_o,
   output logic [EV_AW-1:0] rd_ptr_o,
   output logic             empty_o,
   output logic             full_o
);
   logic [EV_AW:0] wr_q, rd_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q <= '0;
         rd_q <= '0;
      end else begin
         if (commit_i)             wr_q <= wr_q + 1'b1;
         if (rd_ack_i && !empty_o) rd_q <= rd_q + 1'b1;
      end
   end

   assign wr_ptr_o = wr_q[EV_AW-1:0];
   assign rd_ptr_o = rd_q[EV_AW-1:0];
   assign empty_o  = (wr_q == rd_q);
   assign full_o   = (wr_q[EV_AW] != rd_q[EV_AW]) && (wr_q[EV_AW-1:0] == rd_q[EV_AW-1:0]);
endmodule

// File: rtl/evb_memport.sv
module evb_memport #(
   parameter int DATA_W = 32,
   parameter int VAL_W  = 16,
   parameter int CH_W   = 6,
   parameter int GEO_W  = 5,
   parameter int EV_AW  = 4,
   parameter int IDX_W  = 9,
   parameter int MEM_AW = EV_AW + IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              open_i,
   input  logic              start_i,
   input  logic [EV_AW-1:0]  wr_ptr_i,
   input  logic [GEO_W-1:0]  geo_i,
   input  logic              acq_we_i,
   input  logic [CH_W-1:0]   acq_chan_i,
   input  logic [VAL_W-1:0]  acq_val_i,
   input  logic              host_we_i,
   input  logic              host_burst_i,
   input  logic [MEM_AW-1:0] host_addr_i,
   input  logic [DATA_W-1:0] host_wdata_i,
   output logic              acq_take_o,
   output logic              mem_we_o,
   output logic [MEM_AW-1:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   output logic              host_nak_o
);
   logic [IDX_W-1:0]  widx_q;
   logic              slot_full_q;
   logic              host_take;
   logic [DATA_W-1:0] acq_word;

   always_comb begin
      acq_word = '0;
      acq_word[VAL_W-1:0]             = acq_val_i;
      acq_word[VAL_W +: CH_W]         = acq_chan_i;
      acq_word[VAL_W+CH_W +: GEO_W]   = geo_i;
      acq_word[DATA_W-1]              = ^acq_word[DATA_W-2:0];
   end

   assign acq_take_o = acq_we_i && open_i && !slot_full_q;
   assign host_take  = host_we_i && !host_burst_i && !acq_take_o;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         widx_q      <= '0;
         slot_full_q <= 1'b0;
         mem_we_o    <= 1'b0;
         mem_addr_o  <= '0;
         mem_wdata_o <= '0;
         host_nak_o  <= 1'b0;
      end else begin
         if (start_i) begin
            widx_q      <= '0;
            slot_full_q <= 1'b0;
         end else if (acq_take_o) begin
            if (widx_q == {IDX_W{1'b1}}) slot_full_q <= 1'b1;
            else                          widx_q      <= widx_q + 1'b1;
         end
         mem_we_o   <= acq_take_o || host_take;
         host_nak_o <= host_we_i && !host_take;
         if (acq_take_o) begin
            mem_addr_o  <= {wr_ptr_i, widx_q};
            mem_wdata_o <= acq_word;
         end else if (host_take) begin
            mem_addr_o  <= host_addr_i;
            mem_wdata_o <= host_wdata_i;
         end
      end
   end
endmodule

// File: rtl/evbuf_mgr.sv
module evbuf_mgr #(
   parameter int  EVENTS      = 16,
   parameter int  MEM_WORDS   = 8192,
   parameter int  DATA_W      = 32,
   parameter int  VAL_W       = 16,
   parameter int  CH_W        = 6,
   parameter int  GEO_W       = 5,
   parameter int  CLR_BIT     = 31,
   parameter int  FCW_CYC     = 16,
   parameter int  CLK_MHZ     = 125,
   parameter int  RECOVER_NS  = 1000,
   parameter int  SYNC_STAGES = 2,
   localparam int EV_AW       = $clog2(EVENTS),
   localparam int MEM_AW      = $clog2(MEM_WORDS),
   localparam int IDX_W       = MEM_AW - EV_AW,
   localparam int REC_CYC     = CLK_MHZ * RECOVER_NS / 1000,
   localparam int CNT_MAX     = (FCW_CYC > REC_CYC) ? FCW_CYC : REC_CYC,
   localparam int CNT_W       = $clog2(CNT_MAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              gate_i,
   output logic              ready_o,
   input  logic              fc_panel_i,
   input  logic              fc_trig_i,
   input  logic              fc_bcast_i,
   input  logic              csr0_we_i,
   input  logic [DATA_W-1:0] csr0_wdata_i,
   input  logic [GEO_W-1:0]  geo_i,
   input  logic              acq_we_i,
   input  logic [CH_W-1:0]   acq_chan_i,
   input  logic [VAL_W-1:0]  acq_val_i,
   input  logic              host_we_i,
   input  logic              host_burst_i,
   input  logic [MEM_AW-1:0] host_addr_i,
   input  logic [DATA_W-1:0] host_wdata_i,
   input  logic              rd_ack_i,
   output logic [EV_AW-1:0]  wr_ptr_o,
   output logic [EV_AW-1:0]  rd_ptr_o,
   output logic              empty_o,
   output logic              full_o,
   output logic              mem_we_o,
   output logic [MEM_AW-1:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   output logic              host_nak_o
);
   if (EVENTS < 2 || (EVENTS & (EVENTS - 1)) != 0) begin : g_bad_events
      $error("EVENTS must be a power of two, at least 2");
   end
   if ((MEM_WORDS & (MEM_WORDS - 1)) != 0 || MEM_WORDS < 2 * EVENTS) begin : g_bad_mem
      $error("MEM_WORDS must be a power of two holding at least two words per event");
   end
   if (VAL_W + CH_W + GEO_W >= DATA_W) begin : g_bad_fields
      $error("value, channel and geographic fields leave no room for parity");
   end
   if (CLR_BIT >= DATA_W) begin : g_bad_clrbit
      $error("CLR_BIT outside control word");
   end
   if (FCW_CYC < 1 || REC_CYC < 1) begin : g_bad_timing
      $error("window and recovery must each last at least one cycle");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("SYNC_STAGES must lie in 0..4");
   end

   logic clr_req, clr_take, commit, start, open_win, acq_take;

   evb_clrmerge #(.DATA_W(DATA_W), .CLR_BIT(CLR_BIT), .SYNC_STAGES(SYNC_STAGES)) u_clr (
      .clk(clk), .rst_n(rst_n), .panel_i(fc_panel_i), .trig_i(fc_trig_i),
      .bcast_i(fc_bcast_i), .csr_we_i(csr0_we_i), .csr_wdata_i(csr0_wdata_i),
      .clr_req_o(clr_req)
   );

   evb_seq #(.FCW_CYC(FCW_CYC), .REC_CYC(REC_CYC), .CNT_W(CNT_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .gate_i(gate_i), .full_i(full_o), .clr_req_i(clr_req),
      .ready_o(ready_o), .open_o(open_win), .start_o(start), .commit_o(commit),
      .clr_take_o(clr_take)
   );

   evb_ptrs #(.EV_AW(EV_AW)) u_ptrs (
      .clk(clk), .rst_n(rst_n), .commit_i(commit), .rd_ack_i(rd_ack_i),
      .wr_ptr_o(wr_ptr_o), .rd_ptr_o(rd_ptr_o), .empty_o(empty_o), .full_o(full_o)
   );

   evb_memport #(.DATA_W(DATA_W), .VAL_W(VAL_W), .CH_W(CH_W), .GEO_W(GEO_W),
                 .EV_AW(EV_AW), .IDX_W(IDX_W), .MEM_AW(MEM_AW)) u_mem (
      .clk(clk), .rst_n(rst_n), .open_i(open_win), .start_i(start), .wr_ptr_i(wr_ptr_o),
      .geo_i(geo_i), .acq_we_i(acq_we_i), .acq_chan_i(acq_chan_i), .acq_val_i(acq_val_i),
      .host_we_i(host_we_i), .host_burst_i(host_burst_i), .host_addr_i(host_addr_i),
      .host_wdata_i(host_wdata_i), .acq_take_o(acq_take), .mem_we_o(mem_we_o),
      .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .host_nak_o(host_nak_o)
   );
endmodule

// File: rtl/evb_chk.sv
module evb_chk #(
   parameter int EV_AW   = 4,
   parameter int REC_CYC = 125
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ready_o,
   input logic             full_o,
   input logic             empty_o,
   input logic [EV_AW-1:0] wr_ptr_o,
   input logic [EV_AW-1:0] rd_ptr_o,
   input logic             rd_ack_i,
   input logic             clr_take,
   input logic             commit,
   input logic             host_we_i,
   input logic             host_burst_i,
   input logic             acq_take,
   input logic             mem_we_o,
   input logic             host_nak_o
);
   localparam int RW = $clog2(REC_CYC + 1) + 1;
   logic [RW-1:0] rec_left;

   always_ff @(posedge clk) begin
      if (!rst_n)             rec_left <= '0;
      else if (clr_take)      rec_left <= RW'(REC_CYC);
      else if (rec_left != 0) rec_left <= rec_left - 1'b1;
   end

   assert_commit_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> wr_ptr_o == $past(wr_ptr_o) + 1'b1);

   assert_clear_keeps_ptr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      clr_take |=> $stable(wr_ptr_o));

   assert_recovery_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rec_left != 0 |-> !ready_o);

   assert_full_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
      full_o |-> !ready_o);

   assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(full_o && empty_o));

   assert_empty_ack_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (empty_o && rd_ack_i) |=> $stable(rd_ptr_o));

   assert_burst_no_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (host_we_i && host_burst_i && !acq_take) |=> (!mem_we_o && host_nak_o));

   assert_collision_nak_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (host_we_i && acq_take) |=> (mem_we_o && host_nak_o));
endmodule

bind evbuf_mgr evb_chk #(.EV_AW(EV_AW), .REC_CYC(REC_CYC)) u_chk (
   .clk(clk), .rst_n(rst_n), .ready_o(ready_o), .full_o(full_o), .empty_o(empty_o),
   .wr_ptr_o(wr_ptr_o), .rd_ptr_o(rd_ptr_o), .rd_ack_i(rd_ack_i), .clr_take(clr_take),
   .commit(commit), .host_we_i(host_we_i), .host_burst_i(host_burst_i),
   .acq_take(acq_take), .mem_we_o(mem_we_o), .host_nak_o(host_nak_o)
);

// File: tb/tb_evbuf_mgr.sv
module tb_evbuf_mgr;
   localparam int EVENTS = 4;
   localparam int MEM_AW = 13;
   localparam int IDX_W  = 11;
   localparam int REC    = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic gate_i = 0, fc_panel_i = 0, fc_trig_i = 0, fc_bcast_i = 0, csr0_we_i = 0;
   logic [31:0] csr0_wdata_i = '0;
   logic [4:0]  geo_i = 5'h15;
   logic        acq_we_i = 0;
   logic [5:0]  acq_chan_i = '0;
   logic [15:0] acq_val_i = '0;
   logic        host_we_i = 0, host_burst_i = 0;
   logic [12:0] host_addr_i = '0;
   logic [31:0] host_wdata_i = '0;
   logic        rd_ack_i = 0;
   logic        ready_o, empty_o, full_o, mem_we_o, host_nak_o;
   logic [1:0]  wr_ptr_o, rd_ptr_o;
   logic [12:0] mem_addr_o;
   logic [31:0] mem_wdata_o;

   int checks = 0, errors = 0;
   int exp_wr = 0, exp_rd = 0;
   logic [44:0] sb_q[$];

   always #4 clk = ~clk;

   evbuf_mgr #(.EVENTS(EVENTS), .MEM_WORDS(8192), .FCW_CYC(6), .CLK_MHZ(125),
               .RECOVER_NS(64), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .gate_i(gate_i), .ready_o(ready_o),
      .fc_panel_i(fc_panel_i), .fc_trig_i(fc_trig_i), .fc_bcast_i(fc_bcast_i),
      .csr0_we_i(csr0_we_i), .csr0_wdata_i(csr0_wdata_i), .geo_i(geo_i),
      .acq_we_i(acq_we_i), .acq_chan_i(acq_chan_i), .acq_val_i(acq_val_i),
      .host_we_i(host_we_i), .host_burst_i(host_burst_i), .host_addr_i(host_addr_i),
      .host_wdata_i(host_wdata_i), .rd_ack_i(rd_ack_i), .wr_ptr_o(wr_ptr_o),
      .rd_ptr_o(rd_ptr_o), .empty_o(empty_o), .full_o(full_o), .mem_we_o(mem_we_o),
      .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .host_nak_o(host_nak_o)
   );

   task automatic chk(string req, logic [44:0] act, logic [44:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] fmt(logic [4:0] g, logic [5:0] c, logic [15:0] v);
      logic [31:0] w;
      w = {5'b0, g, c, v};
      w[31] = ^w[30:0];
      return w;
   endfunction

   function automatic logic exp_ready();
      return (exp_wr - exp_rd) < EVENTS;
   endfunction

   // monitor: pops the scoreboard on every memory write (R9, R10)
   always @(negedge clk) begin
      if (rst_n && mem_we_o) begin
         if (sb_q.size() == 0) chk("R9/R10 unexpected write", {mem_addr_o, mem_wdata_o}, '0);
         else                  chk("R9/R10 memory write", {mem_addr_o, mem_wdata_o}, sb_q.pop_front());
      end
   end

   task automatic host_wr(logic [12:0] a, logic [31:0] d, logic burst);
      @(negedge clk);
      host_we_i = 1; host_addr_i = a; host_wdata_i = d; host_burst_i = burst;
      if (!burst) sb_q.push_back({a, d});
      @(negedge clk);
      host_we_i = 0; host_burst_i = 0;
      chk(burst ? "R11 burst nak" : "R10 single write no nak", 45'(host_nak_o), 45'(burst));
   endtask

   // modes: 0 plain, 1 csr clear, 2 bcast at expiry, 3 panel early, 4 trig early,
   //        5 panel late, 6 bcast during gate + csr bit31 low in window, 7 host collision
   task automatic run_event(int nwords, int mode);
      @(negedge clk) gate_i = 1;
      @(negedge clk);
      for (int i = 0; i < nwords; i++) begin
         acq_we_i = 1; acq_chan_i = 6'(i + 3); acq_val_i = 16'(16'h1200 + i * 37 + mode);
         sb_q.push_back({13'((exp_wr % EVENTS) << IDX_W | i), fmt(geo_i, acq_chan_i, acq_val_i)});
         if (i == 0 && mode == 6) fc_bcast_i = 1;
         if (i == 0 && mode == 7) begin
            host_we_i = 1; host_addr_i = 13'h0042; host_wdata_i = 32'hDEAD0042;
         end
         @(negedge clk);
         fc_bcast_i = 0;
         if (i == 0 && mode == 7) begin
            host_we_i = 0;
            chk("R12 collision nak", 45'(host_nak_o), 45'd1);
         end
      end
      acq_we_i = 0; gate_i = 0;
      case (mode)
         1: begin
            @(negedge clk); csr0_we_i = 1; csr0_wdata_i = 32'h8000_0000;
            @(negedge clk); csr0_we_i = 0;
            @(negedge clk); gate_i = 1;
            repeat (6) @(negedge clk);
            chk("R2 csr clear keeps wr_ptr", 45'(wr_ptr_o), 45'(exp_wr % EVENTS));
            chk("R6 ready low at end of recovery", 45'(ready_o), 45'd0);
            @(negedge clk);
            chk("R6 ready back after recovery", 45'(ready_o), 45'd1);
            gate_i = 0;
            @(negedge clk);
            chk("R6 gate raised in recovery ignored", 45'(ready_o), 45'd1);
         end
         2: begin
            repeat (6) @(negedge clk); fc_bcast_i = 1;
            @(negedge clk); fc_bcast_i = 0;
            chk("R5 clear beats expiry ptr", 45'(wr_ptr_o), 45'(exp_wr % EVENTS));
            chk("R5 clear beats expiry ready", 45'(ready_o), 45'd0);
            repeat (10) @(negedge clk);
            chk("R3 bcast recovered", 45'(ready_o), 45'd1);
         end
         3, 4: begin
            @(negedge clk);
            if (mode == 3) fc_panel_i = 1; else fc_trig_i = 1;
            @(negedge clk); fc_panel_i = 0; fc_trig_i = 0;
            repeat (15) @(negedge clk);
            chk(mode == 3 ? "R3 panel clear" : "R3 trigger clear", 45'(wr_ptr_o), 45'(exp_wr % EVENTS));
            chk("R3 ready after synchronized clear", 45'(ready_o), 45'd1);
         end
         5: begin
            repeat (5) @(negedge clk); fc_panel_i = 1;
            @(negedge clk); fc_panel_i = 0;
            @(negedge clk);
            exp_wr++;
            chk("R4 late panel commit", 45'(wr_ptr_o), 45'(exp_wr % EVENTS));
            repeat (3) @(negedge clk);
            chk("R4 late panel no recovery", 45'(ready_o), 45'(exp_ready()));
         end
         default: begin
            if (mode == 6) begin
               @(negedge clk); csr0_we_i = 1; csr0_wdata_i = 32'h7FFF_FFFF;
               @(negedge clk); csr0_we_i = 0;
               repeat (4) @(negedge clk);
            end else begin
               repeat (6) @(negedge clk);
            end
            chk("R1 no commit before window end", 45'(wr_ptr_o), 45'(exp_wr % EVENTS));
            chk("R1 ready low in window", 45'(ready_o), 45'd0);
            @(negedge clk);
            exp_wr++;
            chk("R1 commit at window end", 45'(wr_ptr_o), 45'(exp_wr % EVENTS));
            chk("R1 ready after commit", 45'(ready_o), 45'(exp_ready()));
            chk("R7 empty after commit", 45'(empty_o), 45'(exp_wr == exp_rd));
         end
      endcase
   endtask

   task automatic rd_ack();
      @(negedge clk) rd_ack_i = 1;
      @(negedge clk) rd_ack_i = 0;
      if (exp_rd != exp_wr) exp_rd++;
      chk("R8 read pointer", 45'(rd_ptr_o), 45'(exp_rd % EVENTS));
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R7 reset flags", {41'd0, ready_o, empty_o, full_o, mem_we_o}, {41'd0, 4'b1100});
      chk("R8 reset pointers", 45'({wr_ptr_o, rd_ptr_o}), 45'd0);

      host_wr(13'h1ABC, 32'h0123_4567, 1'b0);
      host_wr(13'h0007, 32'hFFFF_0000, 1'b0);
      host_wr(13'h0100, 32'hBAD0_BAD0, 1'b1);

      @(negedge clk) csr0_we_i = 1; csr0_wdata_i = 32'h8000_0000;
      @(negedge clk) csr0_we_i = 0;
      chk("R4 csr clear while idle ignored", 45'(ready_o), 45'd1);
      @(negedge clk) fc_bcast_i = 1;
      @(negedge clk) fc_bcast_i = 0;
      chk("R4 bcast while idle ignored", 45'(ready_o), 45'd1);

      run_event(3, 0);
      run_event(2, 1);
      run_event(2, 2);
      run_event(1, 3);
      run_event(1, 4);
      run_event(2, 5);
      run_event(1, 6);
      run_event(2, 7);

      chk("R7 full after four commits", 45'(full_o), 45'd1);
      chk("R7 ready low when full", 45'(ready_o), 45'd0);
      @(negedge clk) gate_i = 1;
      repeat (3) @(negedge clk);
      gate_i = 0;
      repeat (10) @(negedge clk);
      chk("R7 gate ignored when full", 45'(wr_ptr_o), 45'(exp_wr % EVENTS));
      rd_ack();
      chk("R7 full clears after readout", 45'(full_o), 45'd0);
      chk("R7 ready after readout", 45'(ready_o), 45'd1);
      rd_ack(); rd_ack(); rd_ack();
      chk("R7 empty after draining", 45'(empty_o), 45'd1);
      rd_ack();
      chk("R8 ack when empty ignored", 45'(rd_ptr_o), 45'(exp_rd % EVENTS));

      run_event(2, 0);
      repeat (3) @(negedge clk);
      chk("R9 all writes observed", 45'(sb_q.size()), 45'd0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule